// File: doc/BRIEF.md
# Doorbell Trigger Unit for Inter-Processor and Message-Signalled Interrupts

This block raises per-CPU doorbells. One global trigger register takes a single 32-bit word. The word holds a doorbell number and a bitmap of target CPUs. Every selected CPU then latches that doorbell in its own 32-bit cause register. Inter-processor messages and message-signalled interrupt writes from a PCIe-style master both arrive through this one trigger word.

Each CPU also has a doorbell mask and two source-enable bits. From these the block makes two per-CPU summary lines. The low eight doorbells form the inter-processor group. The upper sixteen doorbells form the message group. Both lines feed an interrupt distributor as per-CPU sources.

Software clears a doorbell by writing zero to its cause bit. It writes the inverse of the bits it has just serviced, so only those bits clear.

Top module: `dbl_trigger_unit`

## Requirements
- R1: After reset, every cause register, every mask register and every source-enable bit is zero, and `ipi_irq` and `msi_irq` are all low.
- R2: A write at global offset 0x04 sets cause bit `trig_wdata[4:0]` in CPU i for each i whose bitmap bit `trig_wdata[8+i]` is 1. The cause registers of the other CPUs do not change. Bitmap bits at positions 8+N_CPU and above have no effect.
- R3: A global write at any offset other than 0x04 changes no cause register.
- R4: A per-CPU write at offset 0x08 clears each cause bit where the written data is 0 and keeps each bit where the data is 1. Such a write never sets a cause bit.
- R5: The per-CPU doorbell mask at offset 0x0C takes all 32 written bits and reads them back. A per-CPU write changes only the CPU selected by `pc_cpu`.
- R6: `ipi_irq[i]` is high exactly when the inter-processor source of CPU i is enabled and some bit of cause[7:0] AND mask[7:0] is 1.
- R7: `msi_irq[i]` is high exactly when the message source of CPU i is enabled and some bit of cause[31:16] AND mask[31:16] is 1. Doorbells 8 to 15 drive neither line. A trigger word of 0xF00 | (n+16) reaches CPUs 0 to 3 with doorbell n+16.
- R8: A per-CPU write at offset 0x4C enables a summary source: data value 0 enables the inter-processor source and data value 1 enables the message source. A write at offset 0x48 with the same values disables that source. Any other data value at either offset is ignored.
- R9: When a trigger write and a clearing cause write hit the same cause bit in the same cycle, the bit ends up set.
- R10: `pc_rdata` returns the cause register of CPU `pc_cpu` at offset 0x08 and its mask register at offset 0x0C. It returns zero at every other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trig_wen | input | 1 | Write strobe for the global register region |
| trig_addr | input | ADDR_W | Offset of the global write |
| trig_wdata | input | 32 | Global write data: doorbell number and CPU bitmap |
| pc_wen | input | 1 | Write strobe for the per-CPU register region |
| pc_cpu | input | CPU_W | CPU bank selected for per-CPU access |
| pc_addr | input | ADDR_W | Offset of the per-CPU access |
| pc_wdata | input | 32 | Per-CPU write data |
| pc_rdata | output | 32 | Per-CPU read data; combinational from the selected bank |
| ipi_irq | output | N_CPU | Per-CPU inter-processor summary line |
| msi_irq | output | N_CPU | Per-CPU message-interrupt summary line |

## Verification
Cause, mask and source-enable state all sit one register away from the ports. A wrong update therefore shows in `pc_rdata` and on the summary lines in the cycle right after the write that caused it.

- A lost trigger shows as a cause read that lacks the expected bit.
- A doorbell on the wrong CPU shows as an unexpected bit in another bank.
- A missed set in a set/clear collision shows as a zero where the set should have won.
- An error in grouping or gating shows as a summary line that rises or stays low against the cause and mask values just read back.

Every check reads the state back through the normal register port. No internal value is looked at directly.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  localparam int DB_W = 32;

  localparam logic [7:0] OFF_TRIG    = 8'h04;
  localparam logic [7:0] OFF_CAUSE   = 8'h08;
  localparam logic [7:0] OFF_MASK    = 8'h0C;
  localparam logic [7:0] OFF_SRC_OFF = 8'h48;
  localparam logic [7:0] OFF_SRC_ON  = 8'h4C;

  localparam logic [DB_W-1:0] GRP_IPI = 32'h0000_00FF;
  localparam logic [DB_W-1:0] GRP_MSI = 32'hFFFF_0000;

  localparam int SRC_IPI  = 0;
  localparam int SRC_MSI  = 1;
  localparam int BMAP_LSB = 8;

  // one-hot vector for a doorbell number
  function automatic logic [DB_W-1:0] db_bit(input logic [4:0] num);
    logic [DB_W-1:0] v;
    v = '0;
    v[num] = 1'b1;
    return v;
  endfunction

  // any pending, unmasked doorbell inside a group
  function automatic logic group_hit(input logic [DB_W-1:0] cause,
                                     input logic [DB_W-1:0] mask,
                                     input logic [DB_W-1:0] grp);
    return |(cause & mask & grp);
  endfunction
endpackage

// File: rtl/dbl_trig_decode.sv
module dbl_trig_decode
  import dbl_pkg::*;
#(
  parameter int N_CPU  = 4,
  parameter int ADDR_W = 8
) (
  input  logic                  trig_wen,
  input  logic [ADDR_W-1:0]     trig_addr,
  input  logic [DB_W-1:0]       trig_wdata,
  output logic [N_CPU*DB_W-1:0] set_flat
);
  localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(OFF_TRIG);

  logic            hit;
  logic [DB_W-1:0] one_db;

  assign hit    = trig_wen && (trig_addr == TRIG_A);
  assign one_db = db_bit(trig_wdata[4:0]);

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    assign set_flat[i*DB_W +: DB_W] =
      (hit && trig_wdata[BMAP_LSB+i]) ? one_db : '0;
  end
endmodule

// File: rtl/dbl_cpu_bank.sv
module dbl_cpu_bank
  import dbl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DB_W-1:0]   set_bits,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DB_W-1:0]   wdata,
  output logic [DB_W-1:0]   cause,
  output logic [DB_W-1:0]   mask,
  output logic [1:0]        src_en,
  output logic              ipi_irq,
  output logic              msi_irq
);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFF_CAUSE);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_SOFF  = ADDR_W'(OFF_SRC_OFF);
  localparam logic [ADDR_W-1:0] A_SON   = ADDR_W'(OFF_SRC_ON);

  logic [DB_W-1:0] cause_d, mask_d;
  logic [1:0]      src_d;
  logic            sel_ipi, sel_msi;

  assign sel_ipi = (wdata == DB_W'(SRC_IPI));
  assign sel_msi = (wdata == DB_W'(SRC_MSI));

  always_comb begin
    cause_d = cause;
    if (wen && addr == A_CAUSE) cause_d = cause & wdata;
    cause_d = cause_d | set_bits;  // set wins over clear
  end

  always_comb begin
    mask_d = mask;
    if (wen && addr == A_MASK) mask_d = wdata;
  end

  always_comb begin
    src_d = src_en;
    if (wen && addr == A_SON) begin
      if (sel_ipi) src_d[SRC_IPI] = 1'b1;
      if (sel_msi) src_d[SRC_MSI] = 1'b1;
    end else if (wen && addr == A_SOFF) begin
      if (sel_ipi) src_d[SRC_IPI] = 1'b0;
      if (sel_msi) src_d[SRC_MSI] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause  <= '0;
      mask   <= '0;
      src_en <= '0;
    end else begin
      cause  <= cause_d;
      mask   <= mask_d;
      src_en <= src_d;
    end
  end

  assign ipi_irq = src_en[SRC_IPI] && group_hit(cause, mask, GRP_IPI);
  assign msi_irq = src_en[SRC_MSI] && group_hit(cause, mask, GRP_MSI);
endmodule

// File: rtl/dbl_trigger_unit.sv
module dbl_trigger_unit
  import dbl_pkg::*;
#(
  parameter int N_CPU  = 4,
  parameter int ADDR_W = 8,
  localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_wen,
  input  logic [ADDR_W-1:0] trig_addr,
  input  logic [31:0]       trig_wdata,
  input  logic              pc_wen,
  input  logic [CPU_W-1:0]  pc_cpu,
  input  logic [ADDR_W-1:0] pc_addr,
  input  logic [31:0]       pc_wdata,
  output logic [31:0]       pc_rdata,
  output logic [N_CPU-1:0]  ipi_irq,
  output logic [N_CPU-1:0]  msi_irq
);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFF_CAUSE);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFF_MASK);

  // named internal events, also used by the checker
  logic [N_CPU*DB_W-1:0] set_all;
  logic [N_CPU*DB_W-1:0] cause_all;
  logic [N_CPU*DB_W-1:0] mask_all;
  logic [N_CPU*2-1:0]    src_en_all;
  logic [N_CPU-1:0]      bank_wen;

  dbl_trig_decode #(.N_CPU(N_CPU), .ADDR_W(ADDR_W)) u_dec (
    .trig_wen  (trig_wen),
    .trig_addr (trig_addr),
    .trig_wdata(trig_wdata),
    .set_flat  (set_all)
  );

  for (genvar i = 0; i < N_CPU; i++) begin : g_bank
    assign bank_wen[i] = pc_wen && (pc_cpu == CPU_W'(i));
    dbl_cpu_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_bits(set_all[i*DB_W +: DB_W]),
      .wen     (bank_wen[i]),
      .addr    (pc_addr),
      .wdata   (pc_wdata),
      .cause   (cause_all[i*DB_W +: DB_W]),
      .mask    (mask_all[i*DB_W +: DB_W]),
      .src_en  (src_en_all[i*2 +: 2]),
      .ipi_irq (ipi_irq[i]),
      .msi_irq (msi_irq[i])
    );
  end

  always_comb begin
    pc_rdata = '0;
    for (int i = 0; i < N_CPU; i++) begin
      if (pc_cpu == CPU_W'(i)) begin
        if (pc_addr == A_CAUSE) pc_rdata = cause_all[i*DB_W +: DB_W];
        else if (pc_addr == A_MASK) pc_rdata = mask_all[i*DB_W +: DB_W];
      end
    end
  end
endmodule

// File: rtl/dbl_trigger_unit_chk.sv
module dbl_trigger_unit_chk #(
  parameter int N_CPU = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_CPU*32-1:0] set_all,
  input logic [N_CPU*32-1:0] cause_all,
  input logic [N_CPU*2-1:0]  src_en_all,
  input logic [N_CPU-1:0]    ipi_irq,
  input logic [N_CPU-1:0]    msi_irq
);
  // R2 / R9: a requested set is present the next cycle, even against a clear
  a_r9_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_all) |=> ((cause_all & $past(set_all)) == $past(set_all)));

  // R4: no cause bit rises without a trigger
  a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_all & ~$past(cause_all) & ~$past(set_all)) == '0));

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    // R6
    a_r6_ipi_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ipi_irq[i] |-> ((|cause_all[i*32 +: 8]) && src_en_all[i*2]));
    // R7
    a_r7_msi_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
      msi_irq[i] |-> ((|cause_all[i*32+16 +: 16]) && src_en_all[i*2+1]));
  end
endmodule

bind dbl_trigger_unit dbl_trigger_unit_chk #(.N_CPU(N_CPU)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .set_all   (set_all),
  .cause_all (cause_all),
  .src_en_all(src_en_all),
  .ipi_irq   (ipi_irq),
  .msi_irq   (msi_irq)
);

// File: tb/dbl_trigger_unit_bench.sv
module dbl_trigger_unit_bench;
  localparam int N_CPU = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_wen = 1'b0;
  logic [7:0]  trig_addr = '0;
  logic [31:0] trig_wdata = '0;
  logic        pc_wen = 1'b0;
  logic [1:0]  pc_cpu = '0;
  logic [7:0]  pc_addr = '0;
  logic [31:0] pc_wdata = '0;
  logic [31:0] pc_rdata;
  logic [3:0]  ipi_irq, msi_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;  // 50 MHz

  dbl_trigger_unit #(.N_CPU(N_CPU), .ADDR_W(8)) u_dbl_trigger_unit (
    .clk(clk), .rst_n(rst_n),
    .trig_wen(trig_wen), .trig_addr(trig_addr), .trig_wdata(trig_wdata),
    .pc_wen(pc_wen), .pc_cpu(pc_cpu), .pc_addr(pc_addr), .pc_wdata(pc_wdata),
    .pc_rdata(pc_rdata), .ipi_irq(ipi_irq), .msi_irq(msi_irq)
  );

  // {trigger word, cpu to read, expected cause}
  localparam logic [65:0] VECS [0:6] = '{
    {32'h0000_0105, 2'd0, 32'h0000_0020},
    {32'h0000_0105, 2'd1, 32'h0000_0000},
    {32'h0000_0F13, 2'd3, 32'h0008_0000},
    {32'h0000_0A1F, 2'd1, 32'h8000_0000},
    {32'h0000_0A1F, 2'd2, 32'h0000_0000},
    {32'h0000_0400, 2'd2, 32'h0000_0001},
    {32'h0000_1003, 2'd0, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pc_write(input logic [1:0] cpu, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    pc_wen = 1'b1; pc_cpu = cpu; pc_addr = a; pc_wdata = d;
    @(negedge clk);
    pc_wen = 1'b0;
  endtask

  task automatic g_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    trig_wen = 1'b1; trig_addr = a; trig_wdata = d;
    @(negedge clk);
    trig_wen = 1'b0;
  endtask

  task automatic rd(input logic [1:0] cpu, input logic [7:0] a, output logic [31:0] d);
    pc_cpu = cpu; pc_addr = a;
    #1 d = pc_rdata;
  endtask

  task automatic clr_all();
    for (int c = 0; c < N_CPU; c++) pc_write(2'(c), 8'h08, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: state during and after reset
    check("R1 ipi reset", {28'h0, ipi_irq}, 32'h0);
    check("R1 msi reset", {28'h0, msi_irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < N_CPU; c++) begin
      rd(2'(c), 8'h08, v); check("R1 cause zero", v, 32'h0);
      rd(2'(c), 8'h0C, v); check("R1 mask zero", v, 32'h0);
    end

    // R2: table of trigger words
    for (int k = 0; k < 7; k++) begin
      clr_all();
      g_write(8'h04, VECS[k][65:34]);
      rd(VECS[k][33:32], 8'h08, v);
      check($sformatf("R2 vector %0d", k), v, VECS[k][31:0]);
    end

    // R3: other global offset ignored
    clr_all();
    g_write(8'h08, 32'h0000_0105);
    rd(2'd0, 8'h08, v); check("R3 wrong global offset", v, 32'h0);

    // R4: clear by writing inverse of serviced bits
    g_write(8'h04, 32'h0000_0103);
    g_write(8'h04, 32'h0000_0105);
    pc_write(2'd0, 8'h08, ~32'h0000_0020);
    rd(2'd0, 8'h08, v); check("R4 selective clear", v, 32'h0000_0008);
    pc_write(2'd0, 8'h08, 32'hFFFF_FFFF);
    rd(2'd0, 8'h08, v); check("R4 write never sets", v, 32'h0000_0008);

    // R5: mask readback and bank isolation
    pc_write(2'd2, 8'h0C, 32'hA5A5_5A5A);
    rd(2'd2, 8'h0C, v); check("R5 mask readback", v, 32'hA5A5_5A5A);
    rd(2'd1, 8'h0C, v); check("R5 other bank mask", v, 32'h0);

    // R10: unmapped offset reads zero
    rd(2'd2, 8'h10, v); check("R10 unmapped read", v, 32'h0);

    // R6: IPI summary
    clr_all();
    pc_write(2'd0, 8'h0C, 32'h0000_00FF);
    g_write(8'h04, 32'h0000_0102);
    #1 check("R6 ipi source disabled", {28'h0, ipi_irq}, 32'h0);
    pc_write(2'd0, 8'h4C, 32'd0);
    #1 check("R6 ipi raised", {28'h0, ipi_irq}, 32'h1);
    check("R7 msi idle with ipi", {28'h0, msi_irq}, 32'h0);
    pc_write(2'd0, 8'h0C, 32'h0);
    #1 check("R6 ipi masked", {28'h0, ipi_irq}, 32'h0);

    // R7: MSI summary
    clr_all();
    pc_write(2'd1, 8'h0C, 32'hFFFF_0000);
    pc_write(2'd1, 8'h4C, 32'd1);
    g_write(8'h04, 32'h0000_0F00 | (32'd5 + 32'd16));
    #1 check("R7 msi raised on cpu1", {28'h0, msi_irq}, 32'h2);
    check("R7 ipi untouched", {28'h0, ipi_irq}, 32'h0);
    rd(2'd3, 8'h08, v); check("R7 msi reaches cpu3", v, 32'h0020_0000);
    clr_all();
    pc_write(2'd1, 8'h0C, 32'hFFFF_FFFF);
    g_write(8'h04, 32'h0000_020A);
    #1 check("R7 doorbell 10 no line", {28'h0, msi_irq}, 32'h0);

    // R8: source disable / ignored values
    g_write(8'h04, 32'h0000_0214);
    #1 check("R8 msi on before off", {28'h0, msi_irq}, 32'h2);
    pc_write(2'd1, 8'h48, 32'd1);
    #1 check("R8 msi source off", {28'h0, msi_irq}, 32'h0);
    pc_write(2'd1, 8'h4C, 32'd7);
    #1 check("R8 other value ignored", {28'h0, msi_irq}, 32'h0);
    pc_write(2'd1, 8'h4C, 32'd1);
    #1 check("R8 msi source back on", {28'h0, msi_irq}, 32'h2);

    // R9: set beats clear in the same cycle
    clr_all();
    g_write(8'h04, 32'h0000_0101);
    @(negedge clk);
    trig_wen = 1'b1; trig_addr = 8'h04; trig_wdata = 32'h0000_0104;
    pc_wen = 1'b1; pc_cpu = 2'd0; pc_addr = 8'h08; pc_wdata = 32'h0;
    @(negedge clk);
    trig_wen = 1'b0; pc_wen = 1'b0;
    rd(2'd0, 8'h08, v); check("R9 set wins", v, 32'h0000_0010);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule